// File: doc/BRIEF.md
# External Interrupt Line Flag and Enable Unit

This block watches eight external interrupt pins. For each pin it keeps an enable bit and a sticky status flag, and it drives one request per line that is the flag gated by the enable. A two-bit sense code per line chooses what sets the flag: a low level, a falling edge, a rising edge or either edge. The pins are first passed through a two-stage synchronizer, and edges are found by comparing the newest synchronized sample with the one before it.

Software reaches both registers through a small read/write bus. The enable register can be read and written without restriction. The status register can only be cleared, and only through a handshake: a bit is cleared by writing 0 to it after a status read that returned 1 for that bit. Each line has a hidden arm bit that records such a read, and every status write drops all arm bits. Separately, a one-cycle acknowledge per line reports that exception handling for that line has started. In edge modes the acknowledge clears the flag. In low-level mode it clears the flag only when the synchronized pin is already high.

Top module: `extIrqFlagUnit`

## Requirements
- R1: After reset the enable register, the status register, `irqReq` and `irqAny` all read 0.
- R2: With `busSel` high and `busWr` low, `busRdData` shows the enable register when `busAddr`=0 and the status register when `busAddr`=1, with bit n belonging to line n. A write with `busAddr`=0 loads the enable register in full.
- R3: A pin change reaches a flag through the two-stage synchronizer. The flag is visible on the third rising clock edge after the change.
- R4: Sense code 00 (bits 2n+1:2n of `senseSel`) sets flag n whenever the synchronized pin n is low. A pin that stays high sets nothing.
- R5: Sense code 01 sets the flag on a falling edge, 10 on a rising edge and 11 on either edge. A transition in the other direction leaves the flag clear.
- R6: Writing 1 to a status bit never sets or clears it. Writing 0 to a status bit that has not been armed by a read leaves it set.
- R7: A status write of 0 clears a flag that the last status read returned as 1. Any status write drops all arm bits, so a later 0 write without a fresh read does not clear.
- R8: A one-cycle `ackPulse[n]` clears flag n when line n is in an edge mode.
- R9: In low-level mode, `ackPulse[n]` clears flag n only when the synchronized pin n is high. Otherwise the flag stays set.
- R10: If a set condition and a clear (from software or from an acknowledge) fall in the same cycle, the flag ends up set.
- R11: `irqReq[n]` is flag n AND enable n, and `irqAny` is the OR of all eight `irqReq` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | 8 | Asynchronous external interrupt pins |
| senseSel | input | 16 | Two-bit sense code per line |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = enable register, 1 = status register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, 0 when not reading |
| ackPulse | input | 8 | Per-line exception handling acknowledge |
| irqReq | output | 8 | Per-line request (flag AND enable) |
| irqAny | output | 1 | OR of all requests |

## Verification
A new set condition can land in the same cycle as a clear of the same flag. The clear can be an armed status write of 0 or an acknowledge. The bench brings this about on a falling-edge line: it arms the flag by reading it, then drives the pin low and places the write, or the acknowledge, exactly on the edge where the synchronized edge reaches the flag. A later status read must still show the flag set.

// File: rtl/irqFlagPkg.sv
package irqFlagPkg;
  localparam int IRQ_LINES = 8;
  localparam int SENSE_W   = 2;
  localparam int SENSE_BUS = IRQ_LINES * SENSE_W;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } senseMode_e;

  typedef struct packed {
    logic [IRQ_LINES-1:0] setHit;
    logic [IRQ_LINES-1:0] hwClr;
    logic                 stsRd;
    logic                 stsWr;
    logic                 enWr;
  } flagStrobe_t;
endpackage

// File: rtl/irqSenseCtrl.sv
module irqSenseCtrl
  import irqFlagPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_LINES-1:0] pinIn,
  input  logic [SENSE_BUS-1:0] senseSel,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic                 busAddr,
  input  logic [IRQ_LINES-1:0] ackPulse,
  output flagStrobe_t          strobe
);
  localparam int LAST = SYNC_DEPTH - 1;

  logic [IRQ_LINES-1:0] syncQ [SYNC_DEPTH];
  logic [IRQ_LINES-1:0] prevQ;
  logic [IRQ_LINES-1:0] pinNow;
  logic [IRQ_LINES-1:0] setHit;
  logic [IRQ_LINES-1:0] hwClr;

  // Pins idle high, so the synchronizer resets to ones to avoid false edges.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncQ[k] <= '1;
      prevQ <= '1;
    end else begin
      syncQ[0] <= pinIn;
      for (int k = 1; k < SYNC_DEPTH; k++) syncQ[k] <= syncQ[k-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign pinNow = syncQ[LAST];

  for (genvar i = 0; i < IRQ_LINES; i++) begin : g_line
    senseMode_e mode;
    assign mode = senseMode_e'(senseSel[SENSE_W*i +: SENSE_W]);

    always_comb begin
      unique case (mode)
        SENSE_LOW:  setHit[i] = ~pinNow[i];
        SENSE_FALL: setHit[i] = prevQ[i] & ~pinNow[i];
        SENSE_RISE: setHit[i] = ~prevQ[i] & pinNow[i];
        default:    setHit[i] = prevQ[i] ^ pinNow[i];
      endcase
    end

    // Level lines drop their flag on acknowledge only once the pin is back high.
    assign hwClr[i] = ackPulse[i] & ((mode != SENSE_LOW) | pinNow[i]);
  end

  always_comb begin
    strobe.setHit = setHit;
    strobe.hwClr  = hwClr;
    strobe.stsRd  = busSel & ~busWr &  busAddr;
    strobe.stsWr  = busSel &  busWr &  busAddr;
    strobe.enWr   = busSel &  busWr & ~busAddr;
  end

  // R9
  level_ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((senseSel[1:0] == 2'b00) && !pinNow[0]) |-> !hwClr[0]);
endmodule

// File: rtl/irqFlagPath.sv
module irqFlagPath
  import irqFlagPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  flagStrobe_t          strobe,
  input  logic                 busAddr,
  input  logic                 rdActive,
  input  logic [IRQ_LINES-1:0] wrData,
  output logic [IRQ_LINES-1:0] rdData,
  output logic [IRQ_LINES-1:0] flagQ,
  output logic [IRQ_LINES-1:0] enQ
);
  logic [IRQ_LINES-1:0] armQ;
  logic [IRQ_LINES-1:0] swClr;
  logic [IRQ_LINES-1:0] flagNext;

  assign swClr    = strobe.stsWr ? (~wrData & armQ) : '0;
  assign flagNext = (flagQ & ~(swClr | strobe.hwClr)) | strobe.setHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
      armQ  <= '0;
    end else begin
      flagQ <= flagNext;
      if (strobe.enWr) enQ <= wrData;
      if (strobe.stsWr)      armQ <= '0;
      else if (strobe.stsRd) armQ <= armQ | flagQ;
    end
  end

  assign rdData = !rdActive ? '0 : (busAddr ? flagQ : enQ);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setHit != '0) |=> ((flagQ & $past(strobe.setHit)) == $past(strobe.setHit)));

  // R6
  no_false_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setHit == '0) |=> ((flagQ & ~$past(flagQ)) == '0));

  // R6
  unarmed_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stsWr && strobe.hwClr == '0) |=> ((($past(flagQ) & ~$past(armQ)) & ~flagQ) == '0));

  // R7
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stsWr |=> (armQ == '0));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.hwClr & ~strobe.setHit) != '0) |=>
      ((flagQ & $past(strobe.hwClr & ~strobe.setHit)) == '0));
endmodule

// File: rtl/extIrqFlagUnit.sv
module extIrqFlagUnit
  import irqFlagPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  pinIn,
  input  logic [15:0] senseSel,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        busAddr,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic [7:0]  ackPulse,
  output logic [7:0]  irqReq,
  output logic        irqAny
);
  flagStrobe_t          strobe;
  logic [IRQ_LINES-1:0] flagQ;
  logic [IRQ_LINES-1:0] enQ;

  irqSenseCtrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .senseSel (senseSel),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .ackPulse (ackPulse),
    .strobe   (strobe)
  );

  irqFlagPath u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busAddr  (busAddr),
    .rdActive (busSel & ~busWr),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .flagQ    (flagQ),
    .enQ      (enQ)
  );

  assign irqReq = flagQ & enQ;
  assign irqAny = |irqReq;

  // R11
  req_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr && busRdData == '0) |-> !irqAny);
endmodule

// File: tb/extIrqFlagUnit_bench.sv
module extIrqFlagUnit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  pinIn;
  logic [15:0] senseSel;
  logic        busSel, busWr, busAddr;
  logic [7:0]  busWrData, busRdData;
  logic [7:0]  ackPulse;
  logic [7:0]  irqReq;
  logic        irqAny;

  int checkCount = 0;
  int failCount  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  extIrqFlagUnit u_extIrqFlagUnit (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .senseSel(senseSel),
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .ackPulse(ackPulse), .irqReq(irqReq), .irqAny(irqAny)
  );

  // {line[2:0], mode[1:0], pinFrom, pinTo, expectFlag}
  localparam logic [7:0] VEC [8] = '{
    {3'd0, 2'b00, 1'b1, 1'b0, 1'b1},
    {3'd1, 2'b00, 1'b1, 1'b1, 1'b0},
    {3'd2, 2'b01, 1'b1, 1'b0, 1'b1},
    {3'd3, 2'b01, 1'b0, 1'b1, 1'b0},
    {3'd4, 2'b10, 1'b0, 1'b1, 1'b1},
    {3'd5, 2'b10, 1'b1, 1'b0, 1'b0},
    {3'd6, 2'b11, 1'b1, 1'b0, 1'b1},
    {3'd7, 2'b11, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic addr, output logic [7:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    #1 data = busRdData;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] data);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWrData = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic ack(input logic [7:0] mask);
    @(negedge clk) ackPulse = mask;
    @(negedge clk) ackPulse = '0;
  endtask

  task automatic clearAll();
    logic [7:0] d;
    busRead(1'b1, d);
    busWrite(1'b1, 8'h00);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*50000);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checkCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rstN = 1'b0; pinIn = 8'hFF; senseSel = '0;
    busSel = 1'b0; busWr = 1'b0; busAddr = 1'b0; busWrData = '0; ackPulse = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(1'b0, d); check("R1 enable", d, 8'h00);
    busRead(1'b1, d); check("R1 status", d, 8'h00);
    check("R1 irqReq", irqReq, 8'h00);
    check("R1 irqAny", {7'd0, irqAny}, 8'h00);

    // R2 enable register
    busWrite(1'b0, 8'hA5);
    busRead(1'b0, d); check("R2 enable rw", d, 8'hA5);
    busWrite(1'b0, 8'h00);

    // R3 R4 R5 sense modes from the vector table
    for (int v = 0; v < 8; v++) begin
      logic [2:0] vLine;
      logic [1:0] vMode;
      vLine = VEC[v][7:5];
      vMode = VEC[v][4:3];
      @(negedge clk) pinIn = 8'hFF;
      repeat (4) @(negedge clk);
      senseSel = 16'(vMode) << (2*vLine);
      pinIn[vLine] = VEC[v][2];
      repeat (4) @(negedge clk);
      clearAll();
      @(negedge clk) pinIn[vLine] = VEC[v][1];
      settle();
      busRead(1'b1, d);
      check(vMode == 2'b00 ? "R4 level vector" : "R5 R3 edge vector",
            d, 8'(VEC[v][0]) << vLine);
    end
    @(negedge clk) pinIn = 8'hFF;
    repeat (4) @(negedge clk);
    senseSel = 16'h0010;   // line2 falling edge, rest low level
    clearAll();

    // R6 write 1 and unarmed write 0
    @(negedge clk) pinIn[2] = 1'b0;
    settle();
    busWrite(1'b1, 8'hFF);
    busRead(1'b1, d); check("R6 write one no effect", d, 8'h04);
    busWrite(1'b1, 8'hFF);
    busWrite(1'b1, 8'h00);
    busRead(1'b1, d); check("R6 unarmed zero keeps flag", d, 8'h04);

    // R7 armed clear
    busWrite(1'b1, 8'h00);
    busRead(1'b1, d); check("R7 armed clear", d, 8'h00);

    // R11 request gating
    @(negedge clk) pinIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    pinIn[2] = 1'b0;
    settle();
    @(negedge clk);
    check("R11 gated off", irqReq, 8'h00);
    busWrite(1'b0, 8'h04);
    #1 check("R11 irqReq", irqReq, 8'h04);
    check("R11 irqAny", {7'd0, irqAny}, 8'h01);

    // R8 acknowledge in edge mode
    ack(8'h04);
    busRead(1'b1, d); check("R8 edge ack clears", d, 8'h00);
    check("R11 irqAny after ack", {7'd0, irqAny}, 8'h00);

    // R9 level-mode acknowledge
    @(negedge clk) pinIn[0] = 1'b0;
    settle();
    ack(8'h01);
    busRead(1'b1, d); check("R9 level ack pin low keeps", d, 8'h01);
    @(negedge clk) pinIn[0] = 1'b1;
    settle();
    busRead(1'b1, d); check("R9 sticky after pin high", d, 8'h01);
    ack(8'h01);
    busRead(1'b1, d); check("R9 level ack pin high clears", d, 8'h00);

    // R10 armed software clear collides with a new falling edge
    busRead(1'b1, d);
    @(negedge clk) pinIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    pinIn[2] = 1'b0;
    settle();
    busRead(1'b1, d);          // flag2 set, now armed
    @(negedge clk) pinIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    pinIn[2] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 1'b1; busWrData = 8'h00;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    busRead(1'b1, d); check("R10 set beats sw clear", d, 8'h04);

    // R10 acknowledge collides with a new falling edge
    @(negedge clk) pinIn[2] = 1'b1;
    repeat (4) @(negedge clk);
    pinIn[2] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk) ackPulse = 8'h04;
    @(negedge clk) ackPulse = 8'h00;
    busRead(1'b1, d); check("R10 set beats ack", d, 8'h04);

    $display("TB_RESULT checks=%0d failures=%0d", checkCount, failCount);
    $finish;
  end
endmodule